// File: doc/BRIEF.md
# Dual-Phase Chopping Current Controller

This block is the digital core of a fixed-frequency peak-current chopper for two unipolar stepper windings. One free-running timebase, counted in system clock cycles, produces one discharge event per oscillator period. Successive events are dealt to the channels in turn. With two channels, each channel chops at half the oscillator rate, and the two channels are spaced half a chopping period apart. This keeps their current peaks from lining up in time.

Each channel has a set/reset latch. The channel's sync pulse sets the latch, which turns the high-side drive on. A digital "current above threshold" input from an external comparator passes through a two-flop synchronizer and then clears the latch. The latch stays cleared until the channel's next sync pulse. For a parameterised number of cycles at the start of every oscillator period, the synchronized trip is ignored. This masks the switching spike. While the high side is off, the channel's low-side recirculation enable is raised. Each channel also carries a 2-bit threshold code. The code is captured at the channel's sync pulse and presented as a one-hot selector for the external reference.

Top module: `dual_chop_ctrl`

## Requirements
- R1: While `rst_n` is low, `hs_on`, `ls_on` and `ref_sel` are all zero. They go to zero without waiting for a clock edge.
- R2: The oscillator period is `OSC_CYC` clocks. Counting rising edges after reset release from 1, channel c's high-side drive is set by edge k+1, for every k with k mod (NUM_CH·OSC_CYC) = c·OSC_CYC.
- R3: Channel 1 syncs `OSC_CYC` clocks after channel 0, which places the two channels in antiphase. No two channels ever sync in the same cycle.
- R4: A channel's sync pulse sets its `hs_on` bit on the next clock edge, whatever the state of its trip input.
- R5: A trip raised on `sense_raw[c]` outside the blanking window clears `hs_on[c]` on the third rising edge after it is applied. Two of those edges are synchronizer delay.
- R6: For the first `BLANK_CYC` cycles of every oscillator period, a synchronized trip is ignored. A trip still present when the window ends clears the drive on the following edge.
- R7: Once cleared, `hs_on[c]` stays low until channel c's next sync pulse, even after the trip input drops.
- R8: `ls_on[c]` is high exactly when channel c has synced at least once since reset and `hs_on[c]` is low. `hs_on[c]` and `ls_on[c]` are never both high.
- R9: `level_code[2c+1:2c]` is captured at channel c's sync pulse. `ref_sel[4c+3:4c]` then holds the one-hot value 1<<code, where code 0,1,2,3 select thresholds in the ratio 1:2:3:4.
- R10: A change of `level_code` between sync pulses leaves `ref_sel` unchanged until that channel's next sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_raw | input | NUM_CH | Comparator trip per channel, asynchronous |
| level_code | input | 2·NUM_CH | Threshold code per channel |
| hs_on | output | NUM_CH | High-side drive enable per channel |
| ls_on | output | NUM_CH | Low-side recirculation enable per channel |
| ref_sel | output | 4·NUM_CH | One-hot reference selector per channel |

## Verification
Suppose the phase or period counter is wrong. Then a channel's `hs_on` rises on the wrong edge within the first chopping period, and channel 1's first rise misses edge `OSC_CYC`+1. A blanking window of the wrong length, or a synchronizer of the wrong depth, moves the falling edge of `hs_on` away from the cycle computed from the trip offset. The effect is seen within a few clocks of the trip. A latch that forgets its state, or a selector that reloads too early, shows up before the next sync pulse. In the first case `hs_on` comes back on. In the second, `ref_sel` follows a mid-period code change.

// File: rtl/chop_pkg.sv
package chop_pkg;
  parameter int LVL_W = 2;
  localparam int N_LVL = 1 << LVL_W;

  // one-hot reference selector from a threshold code
  function automatic logic [N_LVL-1:0] level_onehot(input logic [LVL_W-1:0] code);
    return N_LVL'(1) << code;
  endfunction

  // true while the period position lies inside the comparator lockout
  function automatic logic in_blank(input int unsigned pos, input int unsigned lock);
    return pos < lock;
  endfunction
endpackage

// File: rtl/chop_timebase.sv
module chop_timebase
  import chop_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int OSC_CYC   = 6098,
  parameter int BLANK_CYC = 350
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [NUM_CH-1:0] sync_o,
  output logic              blank_o
);
  localparam int CW = $clog2(OSC_CYC);
  localparam int PW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ph_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(OSC_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PW'(NUM_CH - 1)) ? '0 : ph_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
    assign sync_o[c] = rst_n && (cnt_q == '0) && (ph_q == PW'(c));
  end

  assign blank_o = in_blank(int'(cnt_q), BLANK_CYC);
endmodule

// File: rtl/chop_sync2.sv
module chop_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/chop_channel.sv
module chop_channel
  import chop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic             blank_i,
  input  logic             trip_i,
  input  logic [LVL_W-1:0] code_i,
  output logic             hs_o,
  output logic             ls_o,
  output logic [N_LVL-1:0] ref_o
);
  logic             hs_q;
  logic             started_q;
  logic [N_LVL-1:0] ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b0;
      started_q <= 1'b0;
      ref_q     <= '0;
    end else if (sync_i) begin
      hs_q      <= 1'b1;
      started_q <= 1'b1;
      ref_q     <= level_onehot(code_i);
    end else if (trip_i && !blank_i) begin
      hs_q      <= 1'b0;
    end
  end

  assign hs_o  = hs_q;
  assign ls_o  = started_q && !hs_q;
  assign ref_o = ref_q;
endmodule

// File: rtl/dual_chop_ctrl.sv
module dual_chop_ctrl
  import chop_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int OSC_CYC   = 6098,
  parameter int BLANK_CYC = 350
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       sense_raw,
  input  logic [NUM_CH*LVL_W-1:0] level_code,
  output logic [NUM_CH-1:0]       hs_on,
  output logic [NUM_CH-1:0]       ls_on,
  output logic [NUM_CH*N_LVL-1:0] ref_sel
);
  logic [NUM_CH-1:0] sync_w;
  logic [NUM_CH-1:0] trip_w;
  logic              blank_w;

  chop_timebase #(
    .NUM_CH(NUM_CH), .OSC_CYC(OSC_CYC), .BLANK_CYC(BLANK_CYC)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .sync_o(sync_w), .blank_o(blank_w)
  );

  chop_sync2 #(.W(NUM_CH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sense_raw), .q(trip_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chop_channel u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_w[c]),
      .blank_i(blank_w),
      .trip_i (trip_w[c]),
      .code_i (level_code[c*LVL_W +: LVL_W]),
      .hs_o   (hs_on[c]),
      .ls_o   (ls_on[c]),
      .ref_o  (ref_sel[c*N_LVL +: N_LVL])
    );
  end
endmodule

// File: rtl/dual_chop_ctrl_chk.sv
module dual_chop_ctrl_chk
  import chop_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       sync_w,
  input logic                    blank_w,
  input logic [NUM_CH-1:0]       trip_w,
  input logic [NUM_CH-1:0]       hs_on,
  input logic [NUM_CH-1:0]       ls_on,
  input logic [NUM_CH*N_LVL-1:0] ref_sel
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (hs_on == '0 && ls_on == '0 && ref_sel == '0)); // R1

  AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_w)); // R3

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_SYNC_SETS_HS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_w[c] |=> hs_on[c]); // R4
    AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_w[c] && !blank_w && !sync_w[c]) |=> !hs_on[c]); // R5
    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_on[c] && blank_w) |=> hs_on[c]); // R6
    AST_OFF_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_on[c] && !sync_w[c]) |=> !hs_on[c]); // R7
    AST_HS_LS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on[c] && ls_on[c])); // R8
    AST_REF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ref_sel[c*N_LVL +: N_LVL])); // R9
    AST_REF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_w[c] |=> $stable(ref_sel[c*N_LVL +: N_LVL])); // R10
  end
endmodule

bind dual_chop_ctrl dual_chop_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_w(sync_w), .blank_w(blank_w),
  .trip_w(trip_w), .hs_on(hs_on), .ls_on(ls_on), .ref_sel(ref_sel)
);

// File: tb/dual_chop_ctrl_tb.sv
`timescale 1ns/1ps
module dual_chop_ctrl_tb;
  localparam int P  = 20;
  localparam int B  = 6;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sense_raw = '0;
  logic [3:0]  level_code = '0;
  logic [1:0]  hs_on, ls_on;
  logic [7:0]  ref_sel;
  int          ecount = 0;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  dual_chop_ctrl #(.NUM_CH(NC), .OSC_CYC(P), .BLANK_CYC(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .sense_raw(sense_raw), .level_code(level_code),
    .hs_on(hs_on), .ls_on(ls_on), .ref_sel(ref_sel)
  );

  // ch, code, trip delay after set edge, trip hold cycles
  localparam int VEC [7][4] = '{
    '{0, 0, 0, 10}, '{1, 1, 5, 4}, '{0, 2, 2, 1}, '{1, 3, 0, 2},
    '{0, 3, 10, 1}, '{1, 2, 3, 6}, '{0, 1, 1, 20}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at edge %0d", req, act, exp, ecount);
    end
  endtask

  // edge count, from trip application, on which the drive must fall; 0 = never
  function automatic int exp_fall(input int d, input int h);
    int lim = P - d - 2;
    int m = (B - d > 3) ? B - d : 3;
    if (m <= h + 2 && m <= lim) return m;
    return 0;
  endfunction

  task automatic wait_set(input int ch);
    do @(negedge clk); while (((ecount - 1) % (NC * P)) != ch * P);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1-all act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hs in reset", int'(hs_on), 0);
    chk("R1 ls in reset", int'(ls_on), 0);
    chk("R1 ref in reset", int'(ref_sel), 0);
    rst_n = 1'b1;

    @(negedge clk);  // after edge 1
    chk("R2 R4 ch0 first set", int'(hs_on[0]), 1);
    chk("R9 ch0 ref code0", int'(ref_sel[3:0]), 1);
    chk("R8 ch1 ls before first sync", int'(ls_on[1]), 0);
    chk("R3 ch1 idle", int'(hs_on[1]), 0);
    while (ecount < P) @(negedge clk);
    chk("R3 ch1 not yet set", int'(hs_on[1]), 0);
    @(negedge clk);
    chk("R3 ch1 set at P+1", int'(hs_on[1]), 1);
    chk("R3 ch0 still on", int'(hs_on[0]), 1);

    foreach (VEC[v]) begin
      int ch   = VEC[v][0];
      int code = VEC[v][1];
      int d    = VEC[v][2];
      int h    = VEC[v][3];
      int m    = exp_fall(d, h);
      int lim  = P - d - 2;
      level_code[2*ch +: 2] = 2'(code);
      wait_set(ch);
      chk("R2 R4 set on own sync", int'(hs_on[ch]), 1);
      chk("R8 ls off while on", int'(ls_on[ch]), 0);
      chk("R9 ref one-hot", int'(ref_sel[4*ch +: 4]), 1 << code);
      level_code[2*ch +: 2] = 2'(code ^ 3);
      repeat (d) @(negedge clk);
      sense_raw[ch] = 1'b1;
      for (int i = 1; i <= lim; i++) begin
        int e_hs;
        @(negedge clk);
        if (i == h) sense_raw[ch] = 1'b0;
        e_hs = (m == 0 || i < m) ? 1 : 0;
        if (m == 0)    chk("R6 blanked trip", int'(hs_on[ch]), e_hs);
        else if (i > m) chk("R7 stays off", int'(hs_on[ch]), e_hs);
        else           chk("R5 trip timing", int'(hs_on[ch]), e_hs);
        chk("R8 ls complement", int'(ls_on[ch]), 1 - e_hs);
      end
      sense_raw[ch] = 1'b0;
      chk("R10 ref held mid-period", int'(ref_sel[4*ch +: 4]), 1 << code);
    end

    level_code = 4'b0110;
    wait_set(1);
    chk("R9 ch1 ref code1", int'(ref_sel[7:4]), 2);
    rst_n = 1'b0;
    #1;
    chk("R1 hs async clear", int'(hs_on), 0);
    chk("R1 ls async clear", int'(ls_on), 0);
    chk("R1 ref async clear", int'(ref_sel), 0);
    summary();
  end
endmodule